// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Engine

This block is a serial master that talks to a display panel over a four-wire link. The link runs in clock-idle-low mode with sampling on the rising edge. Every word written to the panel is nine bits long. The leading bit says whether the remaining eight bits are a command (flag 0) or a data parameter (flag 1). Bits go out most significant first.

A host first loads any parameter bytes into a small queue. It then pulses `start` with a command byte and the number of response bytes it expects. The engine lowers the select line and sends the command word, then one word for each queued parameter. After that it clocks in the response. A one-byte response follows the command words directly. A longer response begins with a single dummy clock, which the engine discards, and then continues as plain 8-bit groups. Each received byte is handed out with a one-cycle strobe, in arrival order. The select line rises after the last bit, and a one-cycle completion pulse marks the end of the transaction.

The serial clock is derived from the system clock. Each half of a serial period lasts `HALF_DIV` system cycles.

Top module: `panel_spi9_engine`

## Requirements
- R1: While `cs_n` is high, `sclk` is low. `mosi` changes only at the start of a low phase of `sclk`, never on the cycle `sclk` rises. `miso` is sampled on the cycle `sclk` rises.
- R2: The first word of a transaction is nine bits: a leading 0, then `cmd_byte` bit 7 down to bit 0.
- R3: Each queued parameter byte is sent as a nine-bit word with leading bit 1, followed by the byte MSB first. Words go out in push order, and every queued byte is sent before any read clock.
- R4: The parameter queue holds `PRM_DEPTH` bytes. `prm_full` is high when it holds that many, and a push while full is dropped.
- R5: With `rd_len` = 1, exactly 8 read clocks follow the last written word, with no dummy clock.
- R6: With `rd_len` > 1, one dummy clock follows the last written word, then 8×`rd_len` read clocks. The bit captured on the dummy clock is discarded.
- R7: Each received byte is presented on `rx_byte` with a one-cycle `rx_valid`, assembled MSB first, in arrival order. `mosi` is 0 during read clocks.
- R8: `cs_n` goes low once per transaction, before the first rising edge of `sclk`, and returns high after the last falling edge.
- R9: Every high phase of `sclk`, and every low phase inside a transaction, lasts `HALF_DIV` system clock cycles.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse that coincides with `cs_n` returning high.
- R11: A `start` pulse while `busy` is high is ignored: the serial stream of the running transaction is unchanged and no extra transaction follows.
- R12: After reset, `cs_n` is high, and `sclk`, `mosi`, `busy`, `done` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| cmd_byte | input | 8 | Command value sent in the first word |
| rd_len | input | RD_LEN_W | Number of response bytes to read |
| prm_push | input | 1 | Push `prm_byte` into the parameter queue |
| prm_byte | input | 8 | Parameter byte |
| prm_full | output | 1 | Parameter queue is full |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low panel select |
| mosi | output | 1 | Serial data to the panel |
| miso | input | 1 | Serial data from the panel |

## Verification
The assertions assume that `miso` is settled before each rising serial edge. They also assume that parameter pushes and `start` arrive only from a host that follows the idle/busy protocol. The bench's panel model changes `miso` only right after a rising edge and pushes parameters only while the engine is idle. The one exception is a deliberate `start` issued mid-transaction. Because the model drives a 1 on the dummy clock, any misalignment of the dummy handling appears in the received bytes.

// File: rtl/p9_pkg.sv
package p9_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } p9_state_t;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_PRM,
    PH_DUM,
    PH_RD
  } p9_phase_t;
endpackage

// File: rtl/p9_halfgen.sv
module p9_halfgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  generate
    if (HALF_DIV == 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      logic [CW-1:0] cnt;
      assign tick = en && (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/p9_prm_fifo.sv
module p9_prm_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [PAW-1:0] wr_ptr, rd_ptr;
  logic [CNW-1:0] count;
  logic           do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PAW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PAW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/p9_seq.sv
module p9_seq
  import p9_pkg::*;
#(
  parameter int RD_LEN_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [7:0]          cmd_byte,
  input  logic [RD_LEN_W-1:0] rd_len,
  input  logic                tick,
  input  logic                fifo_empty,
  input  logic [7:0]          fifo_data,
  output logic                fifo_pop,
  input  logic                miso,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                busy,
  output logic                done,
  output logic                rx_valid,
  output logic [7:0]          rx_byte
);
  p9_state_t           state;
  p9_phase_t           ph;
  logic [7:0]          tx_sr, rx_sr;
  logic [3:0]          bits_left;
  logic [RD_LEN_W-1:0] rd_left;
  logic                dummy_pend;
  logic                wr_phase, word_end;

  assign wr_phase = (ph == PH_CMD) || (ph == PH_PRM);
  assign word_end = (state == ST_HIGH) && tick && (bits_left == 4'd0);
  assign fifo_pop = word_end && wr_phase && !fifo_empty;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ph         <= PH_CMD;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      mosi       <= 1'b0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      bits_left  <= '0;
      rd_left    <= '0;
      dummy_pend <= 1'b0;
      done       <= 1'b0;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cs_n       <= 1'b0;
            mosi       <= 1'b0;
            tx_sr      <= cmd_byte;
            bits_left  <= 4'(BYTE_BITS);
            ph         <= PH_CMD;
            rd_left    <= rd_len;
            dummy_pend <= (rd_len > RD_LEN_W'(1));
            state      <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk <= 1'b1;
            if (ph == PH_RD) rx_sr <= {rx_sr[6:0], miso};
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (bits_left != 4'd0) begin
              bits_left <= bits_left - 1'b1;
              mosi      <= wr_phase ? tx_sr[7] : 1'b0;
              tx_sr     <= {tx_sr[6:0], 1'b0};
              state     <= ST_LOW;
            end else begin
              if (ph == PH_RD) begin
                rx_valid <= 1'b1;
                rx_byte  <= rx_sr;
              end
              if (wr_phase && !fifo_empty) begin
                mosi      <= 1'b1;
                tx_sr     <= fifo_data;
                bits_left <= 4'(BYTE_BITS);
                ph        <= PH_PRM;
                state     <= ST_LOW;
              end else if (rd_left != '0) begin
                mosi  <= 1'b0;
                state <= ST_LOW;
                if (dummy_pend) begin
                  ph         <= PH_DUM;
                  bits_left  <= 4'd0;
                  dummy_pend <= 1'b0;
                end else begin
                  ph        <= PH_RD;
                  bits_left <= 4'(BYTE_BITS - 1);
                  rd_left   <= rd_left - 1'b1;
                end
              end else begin
                mosi  <= 1'b0;
                state <= ST_TAIL;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_spi9_engine.sv
module panel_spi9_engine #(
  parameter int HALF_DIV  = 2,
  parameter int PRM_DEPTH = 8,
  parameter int RD_LEN_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [7:0]          cmd_byte,
  input  logic [RD_LEN_W-1:0] rd_len,
  input  logic                prm_push,
  input  logic [7:0]          prm_byte,
  output logic                prm_full,
  output logic                busy,
  output logic                done,
  output logic                rx_valid,
  output logic [7:0]          rx_byte,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso
);
  logic       tick, fifo_empty, fifo_pop;
  logic [7:0] fifo_data;

  p9_halfgen #(.HALF_DIV(HALF_DIV)) u_halfgen (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  p9_prm_fifo #(.DEPTH(PRM_DEPTH), .DW(8)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (prm_push),
    .din  (prm_byte),
    .pop  (fifo_pop),
    .dout (fifo_data),
    .empty(fifo_empty),
    .full (prm_full)
  );

  p9_seq #(.RD_LEN_W(RD_LEN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_byte  (cmd_byte),
    .rd_len    (rd_len),
    .tick      (tick),
    .fifo_empty(fifo_empty),
    .fifo_data (fifo_data),
    .fifo_pop  (fifo_pop),
    .miso      (miso),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .done      (done),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte)
  );
endmodule

// File: rtl/p9_engine_chk.sv
module p9_engine_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic rx_valid,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  localparam int HW = $clog2(HALF_DIV + 1) + 1;

  logic          sclk_q;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      hcnt   <= '0;
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q)    hcnt <= '0;
      else if (hcnt != '1)   hcnt <= hcnt + 1'b1;
    end
  end

  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  a_r1_mosi_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  a_r2_cmd_flag_first: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !mosi);

  a_r8_select_within_busy: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  a_r7_rx_inside_select: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !cs_n);

  a_r9_high_width: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && !sclk) |-> (hcnt == HW'(HALF_DIV - 1)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_releases: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy));
endmodule

bind panel_spi9_engine p9_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .rx_valid(rx_valid),
  .sclk    (sclk),
  .cs_n    (cs_n),
  .mosi    (mosi)
);

// File: tb/panel_spi9_engine_bench.sv
module panel_spi9_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int PRM_DEPTH  = 8;
  localparam int RD_LEN_W   = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic [7:0]          cmd_byte = '0;
  logic [RD_LEN_W-1:0] rd_len = '0;
  logic                prm_push = 1'b0;
  logic [7:0]          prm_byte = '0;
  logic                prm_full, busy, done, rx_valid, sclk, cs_n, mosi;
  logic [7:0]          rx_byte;
  logic                miso_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_spi9_engine #(.HALF_DIV(HALF_DIV), .PRM_DEPTH(PRM_DEPTH), .RD_LEN_W(RD_LEN_W))
  u_panel_spi9_engine (
    .clk(clk), .rst(rst), .start(start), .cmd_byte(cmd_byte), .rd_len(rd_len),
    .prm_push(prm_push), .prm_byte(prm_byte), .prm_full(prm_full), .busy(busy),
    .done(done), .rx_valid(rx_valid), .rx_byte(rx_byte), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso_r)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  bit       exp_bits[$];
  int       exp_len[$];
  logic [7:0] exp_rx[$];
  bit       got_bits[$];
  string    cur_req = "R2";

  // panel model state
  int  rise_cnt = 0;
  int  wr_n = 0;
  bit  rd_bits[$];
  int  r1_viol = 0, r9_viol = 0, cs_falls = 0;
  time t_rise = 0, t_fall = 0;
  bit  fall_ok = 0;

  function automatic logic miso_for(input int k);
    if (k >= wr_n && (k - wr_n) < rd_bits.size()) return rd_bits[k - wr_n];
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin
    if (!rst) begin
      rise_cnt = 0;
      miso_r   = miso_for(0);
      got_bits.delete();
      fall_ok  = 0;
      cs_falls++;
    end
  end

  always @(posedge sclk) begin
    if (!rst && cs_n === 1'b0) begin
      got_bits.push_back(mosi);
      rise_cnt++;
      miso_r = miso_for(rise_cnt);
      if (fall_ok && (($time - t_fall) != HALF_DIV * CLK_PERIOD)) r9_viol++;
      t_rise = $time;
    end
  end

  always @(negedge sclk) begin
    if (!rst && cs_n === 1'b0) begin
      if (($time - t_rise) != HALF_DIV * CLK_PERIOD) r9_viol++;
      t_fall  = $time;
      fall_ok = 1;
    end
  end

  always @(mosi) if (sclk === 1'b1 && !rst) r1_viol++;

  // monitor: serial stream compared when select releases
  always @(posedge cs_n) begin
    if (!rst) begin
      int n;
      bit ok;
      n = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
      chk(got_bits.size() == n, "R8", "rising-edge count", got_bits.size(), n);
      ok = 1;
      for (int i = 0; i < n; i++) begin
        bit e;
        e = exp_bits.pop_front();
        if (i < got_bits.size() && got_bits[i] != e) ok = 0;
      end
      chk(ok, cur_req, "serial bit stream", 0, 1);
      chk(r1_viol == 0, "R1", "mosi moved while sclk high", r1_viol, 0);
      chk(r9_viol == 0, "R9", "half-period width errors", r9_viol, 0);
    end
  end

  // monitor: received bytes
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      logic [7:0] e;
      if (exp_rx.size() == 0) begin
        chk(0, "R7", "unexpected rx byte", rx_byte, 0);
      end else begin
        e = exp_rx.pop_front();
        chk(rx_byte == e, "R7", "rx byte", rx_byte, e);
      end
    end
  end

  logic [7:0] g_prm [16];
  logic [7:0] g_rd  [8];

  task automatic push_word(input bit flag, input logic [7:0] b);
    exp_bits.push_back(flag);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(b[i]);
  endtask

  task automatic run_txn(input logic [7:0] cmd, input int np, input int rl,
                         input bit inject, input string req);
    int neff, tot, falls0;
    neff = (np > PRM_DEPTH) ? PRM_DEPTH : np;
    cur_req = req;
    push_word(1'b0, cmd);
    for (int i = 0; i < neff; i++) push_word(1'b1, g_prm[i]);
    if (rl > 1) exp_bits.push_back(1'b0);
    for (int i = 0; i < 8 * rl; i++) exp_bits.push_back(1'b0);
    tot = 9 * (1 + neff) + ((rl > 1) ? 1 : 0) + 8 * rl;
    exp_len.push_back(tot);
    for (int i = 0; i < rl; i++) exp_rx.push_back(g_rd[i]);
    wr_n = 9 * (1 + neff);
    rd_bits.delete();
    if (rl > 1) rd_bits.push_back(1'b1);   // dummy clock driven high
    for (int i = 0; i < rl; i++)
      for (int b = 7; b >= 0; b--) rd_bits.push_back(g_rd[i][b]);
    for (int i = 0; i < np; i++) begin
      @(negedge clk);
      prm_push = 1'b1;
      prm_byte = g_prm[i];
      @(negedge clk);
      prm_push = 1'b0;
      if (np > PRM_DEPTH && i == PRM_DEPTH - 1)
        chk(prm_full == 1'b1, "R4", "prm_full at depth", prm_full, 1);
    end
    falls0 = cs_falls;
    @(negedge clk);
    start = 1'b1; cmd_byte = cmd; rd_len = RD_LEN_W'(rl);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1; cmd_byte = ~cmd; rd_len = '0;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(cs_n == 1'b1, "R10", "cs_n high with done", cs_n, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle, busy low",
        {done, busy}, 0);
    chk(cs_falls - falls0 == 1, "R8", "select low periods", cs_falls - falls0, 1);
    chk(exp_rx.size() == 0, "R7", "rx bytes outstanding", exp_rx.size(), 0);
    if (inject) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1, "R11", "no transaction from ignored start",
          {busy, cs_n}, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0 && rx_valid == 0,
        "R12", "reset outputs", {cs_n, sclk, mosi, busy, done, rx_valid}, 6'b100000);

    // R2 command only
    run_txn(8'h29, 0, 0, 0, "R2");

    // R3 one parameter: 24-line pixel format word
    g_prm[0] = 8'h70;
    run_txn(8'h3A, 1, 0, 0, "R3");

    // R3 three parameters in order
    g_prm[0] = 8'h02; g_prm[1] = 8'h81; g_prm[2] = 8'hC4;
    run_txn(8'hC2, 3, 0, 0, "R3");

    // R5 single-byte read
    g_rd[0] = 8'hA5;
    run_txn(8'h0A, 0, 1, 0, "R5");

    // R6 three-byte identification-style read with dummy clock
    g_rd[0] = 8'h45; g_rd[1] = 8'h12; g_rd[2] = 8'hC3;
    run_txn(8'h04, 0, 3, 0, "R6");

    // R6 parameters followed by a two-byte read
    g_prm[0] = 8'hFF; g_prm[1] = 8'h00;
    g_rd[0] = 8'h00; g_rd[1] = 8'hFF;
    run_txn(8'h8B, 2, 2, 0, "R6");

    // R4 overflow: nine pushes, only the first PRM_DEPTH sent
    for (int i = 0; i < 9; i++) g_prm[i] = 8'(8'h10 + i * 8'h11);
    run_txn(8'h55, 9, 0, 0, "R4");

    // R11 start during a read transaction is ignored
    g_rd[0] = 8'h3C; g_rd[1] = 8'h96; g_rd[2] = 8'h01; g_rd[3] = 8'h80;
    run_txn(8'h09, 0, 4, 1, "R11");

    // R1 idle check after all traffic
    @(negedge clk);
    chk(sclk == 0 && cs_n == 1, "R1", "idle sclk low", {sclk, cs_n}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule